// File: doc/BRIEF.md
# MDIO Management Master for Clause-22 and Clause-45 PHYs

This block is a management-bus master that a host programs through four word registers to run single frames to external PHY devices. It generates the management clock, serialises each frame onto the data line, releases the line for the turnaround and data phase of reads, and captures the returned data.

Both frame styles share one engine. A start-code field in the configuration register selects between them. For an indirect (clause-45) access, software first runs an address frame: the device number sits in the address register and the target register number in the data register. It then runs a separate read or write frame. A direct (clause-22) access is a single frame.

The register map is fixed at four word offsets. Offset 0 is the configuration register: divider in bits [DIV_W-1:0], preamble enable in bit 16, start code in bits 21:20. Offset 1 is the address register: register/device number in bits 4:0, PHY number in bits 12:8. Offset 2 is the data register, bits 15:0. Offset 3 is the operation register: opcode in bits 1:0, busy flag in bit 31. A write to offset 3 while the block is idle launches a frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: While a frame runs, MDC stays at each level for exactly divider+1 clocks, starting low. The divider is configuration bits [DIV_W-1:0].
- R2: With configuration bit 16 set, a frame opens with 32 ones. The frame then lasts 64 MDC periods. With bit 16 clear, it lasts 32 periods.
- R3: After any preamble, bits go out MSB first in this order: start code (configuration bits 21:20), opcode (operation bits 1:0), PHY number (address bits 12:8), register/device number (address bits 4:0), two turnaround bits, 16 data bits. Each bit is presented while MDC is low.
- R4: For opcode 0 (address) and opcode 1 (write), MDIO is driven for the whole frame. The turnaround bits are 1 then 0, and the data bits come from the data register.
- R5: For opcode 2 (direct read) and opcode 3 (indirect read), the output enable drops after the first 14 bits following the preamble. The master then samples the 16 data bits MSB first, on the clock where MDC is about to rise.
- R6: Busy (operation bit 31) reads as 1 from the cycle after the launching write. It stays 1 for exactly frame bits × 2 × (divider+1) cycles.
- R7: A write to the operation register while busy neither starts a frame nor changes the stored opcode.
- R8: The data register takes the captured value on the clock that busy clears after a read. Address and write frames leave it unchanged.
- R9: Between frames MDC is low and the MDIO output enable is 0.
- R10: All registers reset to zero. A register read returns the value one clock after the offset is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the offset of the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
A wrong bit counter or shift state shows as a mismatch on mdio_o or mdio_oe within one MDC period. It also shows as a busy window whose length differs from frame bits × 2 × (divider+1). A wrong divider count shows on mdc at the next half-period boundary. A capture fault (wrong edge, wrong window or wrong bit order) only reaches the ports as a wrong data register value after the read frame ends. Each read test therefore uses an asymmetric pattern and reads the register back at once.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int DAT_W   = 16;
  localparam int PRE_LEN = 32;

  localparam logic [1:0] OFS_CFG = 2'd0;
  localparam logic [1:0] OFS_ADR = 2'd1;
  localparam logic [1:0] OFS_DAT = 2'd2;
  localparam logic [1:0] OFS_OPR = 2'd3;

  localparam int CFG_PRE_BIT  = 16;
  localparam int CFG_ST_LSB   = 20;
  localparam int ADR_PHY_LSB  = 8;
  localparam int OPR_BUSY_BIT = 31;

  typedef enum logic [1:0] {
    OPC_SETADDR  = 2'd0,
    OPC_WRITE    = 2'd1,
    OPC_READ_DIR = 2'd2,
    OPC_READ_IND = 2'd3
  } opc_e;

  typedef struct packed {
    logic [1:0]       st;
    logic [1:0]       op;
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regad;
    logic [DAT_W-1:0] data;
  } frame_req_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term = run && (cnt == div);
  assign rise = term && !mdc;
  assign fall = term && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  frame_req_t       req,
  input  logic             pre_en,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             active,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic             rd_done,
  output logic [DAT_W-1:0] rd_data
);
  localparam int HDR_W  = 4 + PHY_W + REG_W;
  localparam int BODY_W = HDR_W + 2 + DAT_W;
  localparam int FULL_W = PRE_LEN + BODY_W;
  localparam int CW     = $clog2(FULL_W);

  logic [BODY_W-1:0] body_d, body_oe;
  logic [FULL_W-1:0] vec_d, vec_oe, sh_d, sh_oe;
  logic              req_rd, frm_rd;
  logic [CW-1:0]     rem, rem_init;
  logic [DAT_W-1:0]  cap;

  always_comb begin
    req_rd  = (req.op == OPC_READ_DIR) || (req.op == OPC_READ_IND);
    body_d  = {req.st, req.op, req.phy, req.regad, (req_rd ? 2'b11 : 2'b10), req.data};
    body_oe = req_rd ? {{HDR_W{1'b1}}, {(BODY_W-HDR_W){1'b0}}} : {BODY_W{1'b1}};
    if (pre_en) begin
      vec_d    = {{PRE_LEN{1'b1}}, body_d};
      vec_oe   = {{PRE_LEN{1'b1}}, body_oe};
      rem_init = CW'(FULL_W - 1);
    end else begin
      vec_d    = {body_d, {PRE_LEN{1'b0}}};
      vec_oe   = {body_oe, {PRE_LEN{1'b0}}};
      rem_init = CW'(BODY_W - 1);
    end
  end

  assign done    = active && fall && (rem == '0);
  assign rd_done = done && frm_rd;
  assign rd_data = cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      sh_d    <= '0;
      sh_oe   <= '0;
      rem     <= '0;
      frm_rd  <= 1'b0;
      cap     <= '0;
    end else if (start && !active) begin
      active  <= 1'b1;
      mdio_o  <= vec_d[FULL_W-1];
      mdio_oe <= vec_oe[FULL_W-1];
      sh_d    <= vec_d << 1;
      sh_oe   <= vec_oe << 1;
      rem     <= rem_init;
      frm_rd  <= req_rd;
    end else if (active) begin
      if (rise && frm_rd && (rem < CW'(DAT_W)))
        cap <= {cap[DAT_W-2:0], mdio_i};
      if (fall) begin
        if (rem == '0) begin
          active  <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          mdio_o  <= sh_d[FULL_W-1];
          mdio_oe <= sh_oe[FULL_W-1];
          sh_d    <= sh_d << 1;
          sh_oe   <= sh_oe << 1;
          rem     <= rem - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wen,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             rd_done,
  input  logic [DAT_W-1:0] rd_data,
  output logic [DIV_W-1:0] cfg_div,
  output logic             cfg_pre,
  output logic             start,
  output frame_req_t       req,
  output logic [1:0]       op_q,
  output logic [DAT_W-1:0] data_q
);
  logic [1:0]       cfg_st;
  logic [PHY_W-1:0] phy_q;
  logic [REG_W-1:0] regad_q;
  logic [31:0]      rd_mux;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:22], reg_wdata[19:17]};
  assign start = reg_wen && (reg_addr == OFS_OPR) && !busy;

  always_comb begin
    req.st    = cfg_st;
    req.op    = reg_wdata[1:0];
    req.phy   = phy_q;
    req.regad = regad_q;
    req.data  = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_div <= '0;
      cfg_pre <= 1'b0;
      cfg_st  <= '0;
      phy_q   <= '0;
      regad_q <= '0;
      data_q  <= '0;
      op_q    <= '0;
    end else begin
      if (reg_wen) begin
        case (reg_addr)
          OFS_CFG: begin
            cfg_div <= reg_wdata[DIV_W-1:0];
            cfg_pre <= reg_wdata[CFG_PRE_BIT];
            cfg_st  <= reg_wdata[CFG_ST_LSB +: 2];
          end
          OFS_ADR: begin
            regad_q <= reg_wdata[REG_W-1:0];
            phy_q   <= reg_wdata[ADR_PHY_LSB +: PHY_W];
          end
          OFS_DAT: data_q <= reg_wdata[DAT_W-1:0];
          default: if (!busy) op_q <= reg_wdata[1:0];
        endcase
      end
      if (rd_done) data_q <= rd_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CFG: begin
        rd_mux[DIV_W-1:0]          = cfg_div;
        rd_mux[CFG_PRE_BIT]        = cfg_pre;
        rd_mux[CFG_ST_LSB +: 2]    = cfg_st;
      end
      OFS_ADR: begin
        rd_mux[REG_W-1:0]          = regad_q;
        rd_mux[ADR_PHY_LSB +: PHY_W] = phy_q;
      end
      OFS_DAT: rd_mux[DAT_W-1:0]   = data_q;
      default: begin
        rd_mux[1:0]                = op_q;
        rd_mux[OPR_BUSY_BIT]       = busy;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wen,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             busy, start, cfg_pre, rise, fall, done, rd_done;
  logic [DIV_W-1:0] cfg_div;
  logic [DAT_W-1:0] rd_data, data_q;
  logic [1:0]       op_q;
  frame_req_t       req;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .rd_done(rd_done), .rd_data(rd_data), .cfg_div(cfg_div),
    .cfg_pre(cfg_pre), .start(start), .req(req), .op_q(op_q), .data_q(data_q)
  );

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(cfg_div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .req(req), .pre_en(cfg_pre),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .active(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rd_done(rd_done),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        busy,
  input logic        reg_wen,
  input logic [1:0]  reg_addr,
  input logic [1:0]  op_q,
  input logic [15:0] data_q,
  input logic        rd_done
);
  // R9: clock parked low between frames
  a_r9_idle_mdc: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc);
  // R9: line released between frames
  a_r9_idle_oe: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe);
  // R7: opcode write during a frame is dropped
  a_r7_op_hold: assert property (@(posedge clk) disable iff (rst)
    busy && reg_wen && (reg_addr == 2'd3) |=> $stable(op_q));
  // R8: data register only moves on a software write or a read completion
  a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_wen && (reg_addr == 2'd2)) && !rd_done |=> $stable(data_q));
  // R4: write and address frames drive the line throughout
  a_r4_write_driven: assert property (@(posedge clk) disable iff (rst)
    busy && !op_q[1] |-> mdio_oe);
  // R6: launch while idle raises busy
  a_r6_busy_launch: assert property (@(posedge clk) disable iff (rst)
    !busy && reg_wen && (reg_addr == 2'd3) |=> busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy),
  .reg_wen(reg_wen), .reg_addr(reg_addr), .op_q(op_q), .data_q(data_q),
  .rd_done(rd_done)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wen;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural reference model
  int        m_div, m_t, m_total, m_n;
  bit        m_busy, m_pre, m_rd;
  bit [1:0]  m_st, m_op;
  bit [4:0]  m_phy, m_rg;
  bit [15:0] m_dat, m_pat, phy_pat;
  bit [63:0] m_bv, m_oev;

  function automatic void build(input bit pre, input bit [1:0] st, input bit [1:0] op,
                                input bit [4:0] phy, input bit [4:0] rg, input bit [15:0] dat,
                                output bit [63:0] b, output bit [63:0] o, output int n);
    bit rd = op[1];
    n = 0; b = '0; o = '0;
    if (pre) for (int i = 0; i < 32; i++) begin b[n] = 1; o[n] = 1; n++; end
    for (int i = 1; i >= 0; i--) begin b[n] = st[i]; o[n] = 1; n++; end
    for (int i = 1; i >= 0; i--) begin b[n] = op[i]; o[n] = 1; n++; end
    for (int i = 4; i >= 0; i--) begin b[n] = phy[i]; o[n] = 1; n++; end
    for (int i = 4; i >= 0; i--) begin b[n] = rg[i]; o[n] = 1; n++; end
    for (int i = 1; i >= 0; i--) begin b[n] = (i == 1); o[n] = !rd; n++; end
    for (int i = 15; i >= 0; i--) begin b[n] = dat[i]; o[n] = !rd; n++; end
  endfunction

  always @(posedge clk) begin
    bit [63:0] tb_b, tb_o;
    int tn;
    if (rst) begin
      m_busy <= 0; m_t <= 0; m_div <= 0; m_pre <= 0; m_st <= 0; m_op <= 0;
      m_phy <= 0; m_rg <= 0; m_dat <= 0; m_rd <= 0; m_total <= 0; m_n <= 0;
    end else begin
      if (reg_wen) begin
        case (reg_addr)
          2'd0: begin m_div <= int'(reg_wdata[7:0]); m_pre <= reg_wdata[16]; m_st <= reg_wdata[21:20]; end
          2'd1: begin m_rg <= reg_wdata[4:0]; m_phy <= reg_wdata[12:8]; end
          2'd2: m_dat <= reg_wdata[15:0];
          default: if (!m_busy) begin
            build(m_pre, m_st, reg_wdata[1:0], m_phy, m_rg, m_dat, tb_b, tb_o, tn);
            m_bv <= tb_b; m_oev <= tb_o; m_n <= tn;
            m_total <= tn * 2 * (m_div + 1);
            m_op <= reg_wdata[1:0]; m_rd <= reg_wdata[1];
            m_pat <= phy_pat; m_busy <= 1; m_t <= 0;
          end
        endcase
      end
      if (m_busy) begin
        m_t <= m_t + 1;
        if (m_t + 1 == m_total) begin
          m_busy <= 0;
          if (m_rd) m_dat <= m_pat;
        end
      end
    end
  end

  // PHY side: returns the pattern bits in the data phase of reads, idles high
  always_comb begin
    int hp, bi;
    hp = m_div + 1;
    bi = m_t / (2 * hp);
    mdio_i = 1'b1;
    if (m_busy && m_rd && bi >= m_n - 16) mdio_i = m_pat[4'(m_n - 1 - bi)];
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    int hp, bi;
    bit e_mdc, e_oe, e_o;
    if (!rst && !ended) begin
      hp = m_div + 1;
      bi = m_t / (2 * hp);
      e_mdc = m_busy ? (((m_t / hp) % 2) == 1) : 1'b0;
      e_oe  = m_busy ? m_oev[6'(bi)] : 1'b0;
      e_o   = m_bv[6'(bi)];
      chk(mdc === e_mdc, "R1 R9 mdc level", mdc, e_mdc);
      chk(mdio_oe === e_oe, "R4 R5 R9 mdio_oe", mdio_oe, e_oe);
      if (e_oe) chk(mdio_o === e_o, "R2 R3 mdio_o bit", mdio_o, e_o);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_wen = 0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic poll(output int c);
    logic [31:0] v;
    c = 0;
    forever begin
      rd(2'd3, v);
      if (!v[31]) return;
      c++;
      if (c > 5000) begin
        chk(0, "R6 busy never cleared", c, 0);
        return;
      end
    end
  endtask

  function automatic logic [31:0] cfgw(input int d, input bit pre, input bit [1:0] st);
    return (32'(st) << 20) | (32'(pre) << 16) | 32'(d);
  endfunction

  function automatic logic [31:0] adrw(input bit [4:0] phy, input bit [4:0] rg);
    return (32'(phy) << 8) | 32'(rg);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] v;
    int c;
    rst = 1; reg_wen = 0; reg_addr = 0; reg_wdata = 0; phy_pat = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    rd(2'd0, v); chk(v == 0, "R10 cfg reset value", v, 0);
    rd(2'd3, v); chk(v == 0, "R10 R6 op reset idle", v, 0);
    chk(mdc == 0 && mdio_oe == 0, "R9 idle after reset", {mdc, mdio_oe}, 0);

    // direct write with preamble, divider 1
    wr(2'd0, cfgw(1, 1, 2'b01));
    wr(2'd1, adrw(5'h15, 5'h0A));
    wr(2'd2, 32'h0000_A5C3);
    rd(2'd0, v); chk(v == cfgw(1, 1, 2'b01), "R10 cfg readback", v, cfgw(1, 1, 2'b01));
    rd(2'd1, v); chk(v == adrw(5'h15, 5'h0A), "R10 addr readback", v, adrw(5'h15, 5'h0A));
    wr(2'd3, 32'd1);
    poll(c); chk(c == 64 * 4, "R2 R6 busy length with preamble", c, 64 * 4);
    chk(mdc == 0 && mdio_oe == 0, "R9 idle after write", {mdc, mdio_oe}, 0);
    rd(2'd2, v); chk(v == 32'hA5C3, "R8 write frame keeps data", v, 32'hA5C3);

    // direct read
    phy_pat = 16'h3C5A;
    wr(2'd3, 32'd2);
    poll(c); chk(c == 64 * 4, "R6 read busy length", c, 64 * 4);
    rd(2'd2, v); chk(v == 32'h3C5A, "R5 R8 direct read capture", v, 32'h3C5A);

    // indirect address, read, write; no preamble, divider 0
    wr(2'd0, cfgw(0, 0, 2'b00));
    wr(2'd1, adrw(5'h03, 5'h01));
    wr(2'd2, 32'h0000_1234);
    wr(2'd3, 32'd0);
    poll(c); chk(c == 32 * 2, "R2 R6 busy length no preamble", c, 32 * 2);
    rd(2'd2, v); chk(v == 32'h1234, "R8 address frame keeps data", v, 32'h1234);
    phy_pat = 16'hBEEF;
    wr(2'd3, 32'd3);
    poll(c);
    rd(2'd2, v); chk(v == 32'hBEEF, "R5 R8 indirect read capture", v, 32'hBEEF);
    wr(2'd2, 32'h0000_8001);
    wr(2'd3, 32'd1);
    poll(c); chk(c == 64, "R4 indirect write length", c, 64);
    chk(mdc == 0 && mdio_oe == 0, "R9 idle after indirect write", {mdc, mdio_oe}, 0);

    // ignored launch while busy, divider 3
    wr(2'd0, cfgw(3, 0, 2'b01));
    wr(2'd2, 32'h0000_0F0F);
    phy_pat = 16'h7E81;
    wr(2'd3, 32'd1);
    wr(2'd3, 32'd2);
    rd(2'd3, v); chk(v[1:0] == 2'd1 && v[31], "R7 opcode kept while busy", v, 32'h8000_0001);
    poll(c); chk(c == 32 * 8 - 2, "R7 R1 frame not restarted", c, 32 * 8 - 2);
    rd(2'd2, v); chk(v == 32'h0F0F, "R7 R8 dropped read left data", v, 32'h0F0F);
    rd(2'd3, v); chk(v == 32'd1, "R6 R7 idle opcode readback", v, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule